// File: doc/BRIEF.md
# Pipelined Signed Multiplier with Address Mode

This block multiplies two 32-bit two's-complement operands in a three-stage pipeline and takes a new operation on every clock. A mode input picks between two operations. A plain multiply returns the low half of the 64-bit product and flags overflow when that half cannot hold the product. An address multiply treats only the low 24 bits of each operand as signed numbers. It returns the low 24 bits of their product under the unchanged top byte of the first operand, so that a tag field in the upper byte survives scaling of the offset below it.

Stage 1 conditions the operands and forms radix-4 recoded partial products. The negation increments of those products are collected into a separate correction vector. Stage 2 folds the partial products, the correction vector and a sign-compensation constant into a registered sum/carry pair. Stage 3 adds that pair as two independent 32-bit halves, picks the result word and derives overflow from the high half, the low-half carry and the low-half sign. No 64-bit sum is formed. A valid flag travels with every operation. A synchronous reset clears the valid flags only.

Top module: `mulp_top`

## Requirements
- R1: An operation presented with `in_valid` high on a clock edge appears on the outputs after the third rising edge, counting the capture edge, with `out_valid` high. One operation is accepted per cycle, and a cycle with `in_valid` low yields a cycle with `out_valid` low three edges later.
- R2: While `rst` is high on a rising edge, every pipeline valid flag clears. `out_valid` stays low until an operation issued after reset reaches the output.
- R3: With `in_mode` = 0 (plain multiply), `out_result` equals bits 31..0 of the signed 64-bit product of `op_a` and `op_b`.
- R4: With `in_mode` = 0, `out_ovf` is 1 exactly when product bits 63..32 are not all equal to product bit 31. This includes the case of the most negative operand times -1.
- R5: With `in_mode` = 1 (address multiply), `out_result[31:24]` equals `op_a[31:24]`. `out_result[23:0]` equals bits 23..0 of the product of `op_a[23:0]` and `op_b[23:0]`, each read as a signed 24-bit number. Bits 31..24 of `op_b` have no effect.
- R6: With `in_mode` = 1, `out_ovf` is 1 exactly when that 24-bit by 24-bit product lies outside -2^23 .. 2^23-1.
- R7: Operations of both modes may follow each other in consecutive cycles. Each result uses the mode and operand byte of its own issue cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 1 | 0 = plain multiply, 1 = address multiply |
| op_a | input | 32 | First operand (recoded multiplier; top byte kept in address mode) |
| op_b | input | 32 | Second operand (multiplicand) |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Result word |
| out_ovf | output | 1 | Overflow flag for the result |

## Verification
The bench targets the places where the split overflow rule is fragile. These are the most negative operand times -1, squares on either side of 2^31, and products exactly at ±2^23 in address mode. A design that mishandled the low-half carry or the `0xFFFFFFFE` high-half case would flag valid negative products or miss positive wrap-around. Address-mode vectors carry junk in both top bytes, so a design that failed to sign-extend bit 23, or that mixed the second operand's top byte into the result, returns wrong words. Mixed-mode back-to-back streams, bubbles and a reset taken with operations in flight expose a mode bit or tag byte that slips a stage, and valid flags that survive reset.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

    // Radix-4 recoded digit classes
    typedef enum logic [2:0] {
        BD_ZERO = 3'd0,
        BD_POS1 = 3'd1,
        BD_POS2 = 3'd2,
        BD_NEG1 = 3'd3,
        BD_NEG2 = 3'd4
    } booth_digit_e;

    // Map an overlapping triplet {x[2i+1], x[2i], x[2i-1]} to a digit class
    function automatic booth_digit_e booth_decode(input logic [2:0] trip);
        booth_digit_e d;
        unique case (trip)
            3'b000, 3'b111: d = BD_ZERO;
            3'b001, 3'b010: d = BD_POS1;
            3'b011:         d = BD_POS2;
            3'b100:         d = BD_NEG2;
            default:        d = BD_NEG1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mulp_booth_stage.sv
module mulp_booth_stage
    import mulp_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         in_mode,
    input  logic [W-1:0]                 op_a,
    input  logic [W-1:0]                 op_b,
    output logic                         v1,
    output logic                         mode1,
    output logic [W-AW-1:0]              top1,
    output logic [W/2-1:0][W:0]          pp1,
    output logic [W/2-1:0]               neg1
);
    localparam int TW  = W - AW;
    localparam int NPP = W / 2;
    localparam int PW  = W + 1;

    logic [W-1:0]  pa, pb;
    logic [W:0]    xe;
    logic [PW-1:0] mul1, mul2;
    logic [NPP-1:0][PW-1:0] pp_c;
    logic [NPP-1:0]         neg_c;

    // Operand conditioning: address mode sign-extends bit AW-1
    always_comb begin
        pa = op_a;
        pb = op_b;
        if (in_mode) begin
            pa = {{TW{op_a[AW-1]}}, op_a[AW-1:0]};
            pb = {{TW{op_b[AW-1]}}, op_b[AW-1:0]};
        end
    end

    assign xe   = {pa, 1'b0};
    assign mul1 = {pb[W-1], pb};
    assign mul2 = {pb, 1'b0};

    // One selector per digit; MSB stored inverted (sign compensated in stage 2)
    for (genvar g = 0; g < NPP; g++) begin : g_sel
        logic [PW-1:0] sel;
        always_comb begin
            sel      = '0;
            neg_c[g] = 1'b0;
            unique case (booth_decode(xe[2*g+2 -: 3]))
                BD_ZERO: sel = '0;
                BD_POS1: sel = mul1;
                BD_POS2: sel = mul2;
                BD_NEG1: begin sel = ~mul1; neg_c[g] = 1'b1; end
                BD_NEG2: begin sel = ~mul2; neg_c[g] = 1'b1; end
                default: sel = '0;
            endcase
            pp_c[g] = sel ^ {1'b1, {(PW-1){1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) v1 <= 1'b0;
        else     v1 <= in_valid;
    end

    always_ff @(posedge clk) begin
        mode1 <= in_mode;
        top1  <= op_a[W-1:AW];
        pp1   <= pp_c;
        neg1  <= neg_c;
    end

    // R2: reset empties the first stage
    a_r2_stage1_clear: assert property (@(posedge clk) rst |=> !v1);

endmodule

// File: rtl/mulp_reduce_stage.sv
module mulp_reduce_stage #(
    parameter int W  = 32,
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v1,
    input  logic                 mode1,
    input  logic [W-AW-1:0]      top1,
    input  logic [W/2-1:0][W:0]  pp1,
    input  logic [W/2-1:0]       neg1,
    output logic                 v2,
    output logic                 mode2,
    output logic [W-AW-1:0]      top2,
    output logic [2*W-1:0]       sum2,
    output logic [2*W-1:0]       car2
);
    localparam int NPP  = W / 2;
    localparam int DW   = 2 * W;
    localparam int ROWS = NPP + 2;

    // Compensation for the inverted partial-product sign bits
    function automatic logic [DW-1:0] sign_comp();
        logic [DW-1:0] k;
        k = '0;
        for (int i = 0; i < NPP; i++) k = k + ({{(DW-1){1'b0}}, 1'b1} << (W + 2*i));
        return (~k) + {{(DW-1){1'b0}}, 1'b1};
    endfunction

    localparam logic [DW-1:0] KCONST = sign_comp();

    logic [ROWS-1:0][DW-1:0] rows;
    logic [ROWS-1:0][DW-1:0] cs_s;
    logic [ROWS-1:0][DW-1:0] cs_c;
    logic [DW-1:0]           negv;

    always_comb begin
        negv = '0;
        for (int i = 0; i < NPP; i++) negv[2*i] = neg1[i];
    end

    for (genvar g = 0; g < NPP; g++) begin : g_rows
        assign rows[g] = {{(DW-W-1){1'b0}}, pp1[g]} << (2*g);
    end
    assign rows[NPP]   = negv;
    assign rows[NPP+1] = KCONST;

    // Carry-save chain of 3:2 compressors
    assign cs_s[1] = rows[0];
    assign cs_c[1] = rows[1];
    assign cs_s[0] = '0;
    assign cs_c[0] = '0;
    for (genvar k = 2; k < ROWS; k++) begin : g_csa
        assign cs_s[k] = cs_s[k-1] ^ cs_c[k-1] ^ rows[k];
        assign cs_c[k] = ((cs_s[k-1] & cs_c[k-1]) |
                          (cs_s[k-1] & rows[k])   |
                          (cs_c[k-1] & rows[k])) << 1;
    end

    always_ff @(posedge clk) begin
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
    end

    always_ff @(posedge clk) begin
        mode2 <= mode1;
        top2  <= top1;
        sum2  <= cs_s[ROWS-1];
        car2  <= cs_c[ROWS-1];
    end

    // R1: valid advances one stage per edge
    a_r1_stage2_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (v2 == $past(v1)));

endmodule

// File: rtl/mulp_final_stage.sv
module mulp_final_stage #(
    parameter int W  = 32,
    parameter int AW = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v2,
    input  logic             mode2,
    input  logic [W-AW-1:0]  top2,
    input  logic [2*W-1:0]   sum2,
    input  logic [2*W-1:0]   car2,
    output logic             out_valid,
    output logic [W-1:0]     out_result,
    output logic             out_ovf
);
    localparam logic [W-1:0] ONES  = '1;
    localparam logic [W-1:0] MTWO  = {{(W-1){1'b1}}, 1'b0};

    logic [W:0]   lo_full;
    logic [W-1:0] lo_sum, hi_sum;
    logic         lo_cy;
    logic         hi_ok, nar_ok;
    logic [W-1:0] res_c;
    logic         ovf_c;

    // Two independent half-width adders
    assign lo_full = {1'b0, sum2[W-1:0]} + {1'b0, car2[W-1:0]};
    assign lo_sum  = lo_full[W-1:0];
    assign lo_cy   = lo_full[W];
    assign hi_sum  = sum2[2*W-1:W] + car2[2*W-1:W];

    // High half plus carry must equal the replicated low-half sign
    always_comb begin
        if (lo_sum[W-1])
            hi_ok = (hi_sum == ONES && !lo_cy) || (hi_sum == MTWO && lo_cy);
        else
            hi_ok = (hi_sum == '0 && !lo_cy) || (hi_sum == ONES && lo_cy);
        nar_ok = (lo_sum[W-1:AW-1] == '0) || (&lo_sum[W-1:AW-1]);
    end

    always_comb begin
        if (mode2) begin
            res_c = {top2, lo_sum[AW-1:0]};
            ovf_c = !hi_ok || !nar_ok;
        end else begin
            res_c = lo_sum;
            ovf_c = !hi_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= v2;
    end

    always_ff @(posedge clk) begin
        out_result <= res_c;
        out_ovf    <= ovf_c;
    end

    // R1: output valid follows stage 2 by one edge
    a_r1_out_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(v2)));

endmodule

// File: rtl/mulp_top.sv
module mulp_top #(
    parameter int W  = 32,
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    output logic          out_valid,
    output logic [W-1:0]  out_result,
    output logic          out_ovf
);
    localparam int TW  = W - AW;
    localparam int NPP = W / 2;

    logic                 v1, mode1, v2, mode2;
    logic [TW-1:0]        top1, top2;
    logic [NPP-1:0][W:0]  pp1;
    logic [NPP-1:0]       neg1;
    logic [2*W-1:0]       sum2, car2;

    mulp_booth_stage #(.W(W), .AW(AW)) u_s1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .op_a(op_a), .op_b(op_b), .v1(v1), .mode1(mode1), .top1(top1),
        .pp1(pp1), .neg1(neg1)
    );

    mulp_reduce_stage #(.W(W), .AW(AW)) u_s2 (
        .clk(clk), .rst(rst), .v1(v1), .mode1(mode1), .top1(top1),
        .pp1(pp1), .neg1(neg1), .v2(v2), .mode2(mode2), .top2(top2),
        .sum2(sum2), .car2(car2)
    );

    mulp_final_stage #(.W(W), .AW(AW)) u_s3 (
        .clk(clk), .rst(rst), .v2(v2), .mode2(mode2), .top2(top2),
        .sum2(sum2), .car2(car2), .out_valid(out_valid),
        .out_result(out_result), .out_ovf(out_ovf)
    );

    // Edges since reset, saturating; guards the three-deep look-back below
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R2: reset leaves no valid output
    a_r2_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    // R1: three-edge latency at the ports
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3: plain mode low word matches the product
    a_r3_low_word: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && !$past(in_mode, 3)) |->
        (out_result == W'($past(op_a, 3) * $past(op_b, 3))));

    // R5: address mode keeps the tag byte
    a_r5_tag_byte: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid && $past(in_mode, 3)) |->
        (out_result[W-1:AW] == $past(op_a[W-1:AW], 3)));

endmodule

// File: tb/sim_mulp_top.sv
module sim_mulp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_ovf;

    int checks = 0;
    int failures = 0;

    // Expected pipeline: index 0 = last issue, 2 = issued three steps ago
    logic        q_v [3];
    logic        q_m [3];
    logic [32:0] q_e [3];

    always #2.5 clk = ~clk;

    mulp_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .out_result(out_result), .out_ovf(out_ovf)
    );

    // {mode, op_a, op_b}
    localparam int NV = 18;
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'h00000000, 32'h00000000},
        {1'b0, 32'h00000003, 32'h00000005},
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {1'b0, 32'h80000000, 32'h00000001},
        {1'b0, 32'h80000000, 32'hFFFFFFFF},
        {1'b0, 32'h00010000, 32'h00010000},
        {1'b0, 32'h0000B505, 32'h0000B505},
        {1'b0, 32'h0000B504, 32'h0000B504},
        {1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF},
        {1'b0, 32'hFFFF0000, 32'h00008000},
        {1'b1, 32'hAB000003, 32'hCD000005},
        {1'b1, 32'h12800000, 32'h00FFFFFF},
        {1'b1, 32'h34800000, 32'hEE000001},
        {1'b1, 32'h00001000, 32'hFF000800},
        {1'b1, 32'h990007FF, 32'h55001000},
        {1'b1, 32'h00800000, 32'h00800000},
        {1'b1, 32'hC0FFF001, 32'h3A000800},
        {1'b0, 32'h12345678, 32'h9ABCDEF0}
    };

    function automatic logic [32:0] model(input logic m, input logic [31:0] a,
                                          input logic [31:0] b);
        longint pa, pb, p;
        logic [31:0] r;
        logic o;
        if (m) begin
            pa = longint'({{40{a[23]}}, a[23:0]});
            pb = longint'({{40{b[23]}}, b[23:0]});
            p  = pa * pb;
            r  = {a[31:24], p[23:0]};
            o  = (p < -64'sd8388608) || (p > 64'sd8388607);
        end else begin
            pa = longint'({{32{a[31]}}, a});
            pb = longint'({{32{b[31]}}, b});
            p  = pa * pb;
            r  = p[31:0];
            o  = (p != longint'({{32{p[31]}}, p[31:0]}));
        end
        return {o, r};
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== q_v[2]) begin
            failures++;
            $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, q_v[2]);
        end
        if (q_v[2]) begin
            checks++;
            if (out_result !== q_e[2][31:0]) begin
                failures++;
                if (q_m[2]) $display("FAIL R5 result actual=%h expected=%h", out_result, q_e[2][31:0]);
                else        $display("FAIL R3 result actual=%h expected=%h", out_result, q_e[2][31:0]);
            end
            checks++;
            if (out_ovf !== q_e[2][32]) begin
                failures++;
                if (q_m[2]) $display("FAIL R6 ovf actual=%b expected=%b", out_ovf, q_e[2][32]);
                else        $display("FAIL R4 ovf actual=%b expected=%b", out_ovf, q_e[2][32]);
            end
        end
    endtask

    // Called at a negedge: check, then issue, then advance one cycle
    task automatic step(input logic v, input logic m, input logic [31:0] a,
                        input logic [31:0] b);
        check_out();
        q_v[2] = q_v[1]; q_m[2] = q_m[1]; q_e[2] = q_e[1];
        q_v[1] = q_v[0]; q_m[1] = q_m[0]; q_e[1] = q_e[0];
        q_v[0] = v; q_m[0] = m; q_e[0] = model(m, a, b);
        in_valid = v; in_mode = m; op_a = a; op_b = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_q();
        for (int i = 0; i < 3; i++) begin q_v[i] = 1'b0; q_m[i] = 1'b0; q_e[i] = '0; end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        clear_q();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: valid low during reset
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2 out_valid in reset actual=%b expected=0", out_valid);
        end
        rst = 1'b0;

        // Vector table, back to back (R3 R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) step(1'b1, VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);

        // R1: bubbles between operations
        step(1'b1, 1'b0, 32'h00000007, 32'hFFFFFFFD);
        step(1'b0, 1'b0, 32'hDEADBEEF, 32'hDEADBEEF);
        step(1'b1, 1'b1, 32'h5A7FFFFF, 32'h66000002);
        step(1'b0, 1'b1, '0, '0);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);

        // R7: pseudo-random mixed-mode stream with occasional bubbles
        lcg = 32'h1234ABCD;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg;
            if (lcg[7]) begin ra = ra >>> 16; rb = rb >>> lcg[4:0]; end
            step(lcg[13:11] != 3'b000, lcg[20], ra, rb);
        end
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);

        // R2: reset with operations in flight
        step(1'b1, 1'b0, 32'h00000002, 32'h00000003);
        step(1'b1, 1'b1, 32'hFF000004, 32'h00000005);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_q();
        for (int i = 0; i < 4; i++) begin
            checks++;
            if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R2 out_valid after reset actual=%b expected=0", out_valid);
            end
            step(1'b0, 1'b0, '0, '0);
        end

        // R5: second operand top byte has no effect
        step(1'b1, 1'b1, 32'h01FFFFFE, 32'h00000003);
        step(1'b1, 1'b1, 32'h01FFFFFE, 32'hFF000003);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule